// File: doc/BRIEF.md
# Event Status and Interrupt Controller with Halt and Soft-Reset Handshakes

This block collects the completion and error events of a two-master I2C command engine into one 32-bit sticky status word. A mask word selects which status bits may drive the single interrupt line. Software removes individual status bits by writing a clear word. A separate global-clear write quiets the line until a new unmasked event arrives. Each master signals read completion, a report from each of its two command queues, and ten error conditions, all as one-cycle input pulses.

The block also runs two handshakes. A halt request stops both queues of one master and acknowledges after a fixed delay. A soft-reset command word names the masters to reset. After its own fixed delay the block pulses a reset strobe towards each named master and sets a reset-done acknowledge. Software reaches everything through a simple port: a write strobe, a byte address and 32-bit data, with combinational read data.

Top module: `irq_hub`

## Requirements
- R1: After reset the status and mask words read 0 and the interrupt is low. Offset 0x00 reads the VERSION parameter. Write-only offsets read 0. The address map is: 0x00 version, 0x04 reset command, 0x08 halt request, 0x0C mask (read/write), 0x10 clear, 0x14 status (read-only), 0x18 global clear.
- R2: Each master m (0 or 1) maps its events to status bits. Its read-done pulse `rd_done_i[m]` sets bit 12m. Its queue-0 report pulse `q_report_i[2m]` sets bit 12m+4. Its queue-1 report pulse `q_report_i[2m+1]` sets bit 12m+8.
- R3: Error pulse `err_i[m][k]` sets the k-th lowest set bit of that master's error mask. The mask is 0x18000EE6 for master 0 (so k=0 gives bit 1 and k=9 gives bit 28) and 0x60EE6000 for master 1 (so k=0 gives bit 13).
- R4: Status bits are sticky. A write to 0x10 clears exactly the status bits set in the written value. An event that arrives in the same cycle as the clear of its bit wins, and the bit stays set.
- R5: The interrupt is high when any status bit ANDed with the mask is 1 and the line is armed.
- R6: The line is armed by an event that lands on a masked-in bit. A write of 0x18 with bit 0 set disarms it while the status is left untouched, unless a masked-in event arrives in that same cycle.
- R7: A write to 0x08 with bit m set makes `halt_busy_o[m]` high from the next cycle for HALT_DELAY cycles. Status bit 25+m is then set exactly HALT_DELAY clock edges after the write edge. A further request for the same master while it is busy has no effect on that timing.
- R8: A nonzero write to 0x04 sets status bit 24 exactly RST_DELAY edges after the write edge. In the cycle before that, `mst_reset_o[m]` pulses for each master whose selection bits all appear in the word: 0x000003F1 for master 0 and 0x0003F001 for master 1. The full word 0x0F73F3F7 selects both masters. A zero write starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| rd_done_i | input | 2 | Read-done pulse per master |
| q_report_i | input | 4 | Queue report pulse, index 2*master+queue |
| err_i | input | 2x10 | Error pulses per master |
| irq_o | output | 1 | Interrupt line |
| halt_busy_o | output | 2 | Queues of the master held in halt |
| mst_reset_o | output | 2 | One-cycle reset strobe per master |

## Verification
The bench targets an event and a clear of the same bit in one cycle. A design that lets the clear win there loses a completion. It checks that a global clear quiets the line while the status is untouched, and that only a masked-in event wakes it again. A design that re-arms on any event, or on the clear itself, would leave the line stuck high or never raise it again. The acknowledge timing is checked edge by edge, including a repeated halt request while one is busy and the three selection words of the reset command, so an off-by-one delay, a restarted timer or a wrong strobe decode shows up at once. Random event and register traffic runs against a bench model of the sticky status, the mask and the arming.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int NUM_MST  = 2;
    localparam int NUM_Q    = 2;
    localparam int ERR_W    = 10;
    localparam int STAT_W   = 32;
    localparam int MST_STEP = 12;
    localparam int Q_STEP   = 4;

    localparam int BIT_RST_ACK  = 24;
    localparam int BIT_HALT_ACK = 25;

    localparam logic [STAT_W-1:0] ERR_MASK_M0 = 32'h1800_0EE6;
    localparam logic [STAT_W-1:0] ERR_MASK_M1 = 32'h60EE_6000;
    localparam logic [STAT_W-1:0] RSEL_M0     = 32'h0000_03F1;
    localparam logic [STAT_W-1:0] RSEL_M1     = 32'h0003_F001;

    localparam int OFS_VER    = 'h00;
    localparam int OFS_RST    = 'h04;
    localparam int OFS_HALT   = 'h08;
    localparam int OFS_MASK   = 'h0C;
    localparam int OFS_CLR    = 'h10;
    localparam int OFS_STATUS = 'h14;
    localparam int OFS_GCLR   = 'h18;

    typedef struct packed {
        logic [STAT_W-1:0]  status;
        logic [STAT_W-1:0]  mask;
        logic               armed;
        logic [NUM_MST-1:0] rsel;
    } hub_state_t;

    // position of the k-th lowest set bit of msk
    function automatic int err_pos(input logic [STAT_W-1:0] msk, input int k);
        int seen;
        int pos;
        seen = 0;
        pos  = 0;
        for (int i = 0; i < STAT_W; i++) begin
            if (msk[i]) begin
                if (seen == k) pos = i;
                seen++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/irq_evt_map.sv
module irq_evt_map
    import irq_hub_pkg::*;
(
    input  logic [NUM_MST-1:0]            rd_done_i,
    input  logic [NUM_MST*NUM_Q-1:0]      q_report_i,
    input  logic [NUM_MST-1:0][ERR_W-1:0] err_i,
    input  logic                          rst_ack_i,
    input  logic [NUM_MST-1:0]            halt_ack_i,
    output logic [STAT_W-1:0]             ev_o
);

    always_comb begin
        ev_o = '0;
        for (int m = 0; m < NUM_MST; m++) begin
            ev_o[m*MST_STEP] = rd_done_i[m];
            for (int q = 0; q < NUM_Q; q++) begin
                ev_o[m*MST_STEP + (q+1)*Q_STEP] = q_report_i[m*NUM_Q + q];
            end
            for (int k = 0; k < ERR_W; k++) begin
                ev_o[err_pos((m == 0) ? ERR_MASK_M0 : ERR_MASK_M1, k)] = err_i[m][k];
            end
            ev_o[BIT_HALT_ACK + m] = halt_ack_i[m];
        end
        ev_o[BIT_RST_ACK] = rst_ack_i;
    end

endmodule

// File: rtl/ack_timer.sv
module ack_timer #(
    parameter int DELAY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(DELAY + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == CNT_W'(1)) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(DELAY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign done_o = tmr_q.busy && (tmr_q.cnt == CNT_W'(1));

    // R7
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !tmr_q.busy) |=> (tmr_q.busy && tmr_q.cnt == CNT_W'(DELAY)));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.cnt != CNT_W'(1)) |=> tmr_q.busy);

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter logic [31:0] VERSION    = 32'h0002_0005,
    parameter int          HALT_DELAY = 6,
    parameter int          RST_DELAY  = 10,
    parameter int          ADDR_W     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [31:0]                   wdata_i,
    output logic [31:0]                   rdata_o,
    input  logic [NUM_MST-1:0]            rd_done_i,
    input  logic [NUM_MST*NUM_Q-1:0]      q_report_i,
    input  logic [NUM_MST-1:0][ERR_W-1:0] err_i,
    output logic                          irq_o,
    output logic [NUM_MST-1:0]            halt_busy_o,
    output logic [NUM_MST-1:0]            mst_reset_o
);

    localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] A_RST    = ADDR_W'(OFS_RST);
    localparam logic [ADDR_W-1:0] A_HALT   = ADDR_W'(OFS_HALT);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_GCLR   = ADDR_W'(OFS_GCLR);

    hub_state_t st_d, st_q;

    logic               wr_rst, wr_halt, wr_mask, wr_clr, wr_gclr;
    logic [STAT_W-1:0]  clr_w;
    logic [STAT_W-1:0]  ev;
    logic [NUM_MST-1:0] halt_start, halt_done;
    logic               rst_start, rst_done, rst_busy;
    logic [NUM_MST-1:0] rsel_dec;

    assign wr_rst  = wr_en_i && (addr_i == A_RST);
    assign wr_halt = wr_en_i && (addr_i == A_HALT);
    assign wr_mask = wr_en_i && (addr_i == A_MASK);
    assign wr_clr  = wr_en_i && (addr_i == A_CLR);
    assign wr_gclr = wr_en_i && (addr_i == A_GCLR) && wdata_i[0];
    assign clr_w   = wr_clr ? wdata_i : '0;

    assign rst_start   = wr_rst && (wdata_i != '0);
    assign rsel_dec[0] = ((wdata_i & RSEL_M0) == RSEL_M0);
    assign rsel_dec[1] = ((wdata_i & RSEL_M1) == RSEL_M1);

    generate
        for (genvar m = 0; m < NUM_MST; m++) begin : g_halt
            assign halt_start[m] = wr_halt && wdata_i[m];
            ack_timer #(.DELAY(HALT_DELAY)) u_halt_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (halt_start[m]),
                .busy_o  (halt_busy_o[m]),
                .done_o  (halt_done[m])
            );
        end
    endgenerate

    ack_timer #(.DELAY(RST_DELAY)) u_rst_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rst_start),
        .busy_o  (rst_busy),
        .done_o  (rst_done)
    );

    irq_evt_map u_map (
        .rd_done_i  (rd_done_i),
        .q_report_i (q_report_i),
        .err_i      (err_i),
        .rst_ack_i  (rst_done),
        .halt_ack_i (halt_done),
        .ev_o       (ev)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = (st_q.status & ~clr_w) | ev;
        if (wr_mask) st_d.mask = wdata_i;
        if ((ev & st_q.mask) != '0) st_d.armed = 1'b1;
        else if (wr_gclr)           st_d.armed = 1'b0;
        if (rst_start && !rst_busy) st_d.rsel = rsel_dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o       = st_q.armed && ((st_q.status & st_q.mask) != '0);
    assign mst_reset_o = rst_done ? st_q.rsel : '0;

    always_comb begin
        case (addr_i)
            A_VER:    rdata_o = VERSION;
            A_MASK:   rdata_o = st_q.mask;
            A_STATUS: rdata_o = st_q.status;
            default:  rdata_o = '0;
        endcase
    end

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((st_q.status & $past(ev)) == $past(ev)));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w != '0) |=> ((st_q.status & $past(clr_w & ~ev)) == '0));

    // R6
    gclr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gclr && ((ev & st_q.mask) == '0)) |=> !irq_o);

    // R6
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((ev & st_q.mask) != '0) && !wr_mask) |=> irq_o);

    // R8
    rst_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_reset_o != '0) |=> st_q.status[BIT_RST_ACK]);

endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;

    localparam int HD = 6;
    localparam int RD = 10;
    localparam logic [31:0] VER = 32'h0002_0005;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [4:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [1:0]       rd_done = '0;
    logic [3:0]       q_rep = '0;
    logic [1:0][9:0]  err = '0;
    logic             irq;
    logic [1:0]       hbusy, mrst;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_st = '0;
    logic [31:0] m_mask = '0;
    logic        m_arm = 1'b0;

    always #10 clk = ~clk;

    irq_hub #(.VERSION(VER), .HALT_DELAY(HD), .RST_DELAY(RD), .ADDR_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .rd_done_i(rd_done), .q_report_i(q_rep), .err_i(err),
        .irq_o(irq), .halt_busy_o(hbusy), .mst_reset_o(mrst)
    );

    function automatic int kth(input logic [31:0] msk, input int k);
        int n = 0;
        for (int i = 0; i < 32; i++) begin
            if (msk[i]) begin
                if (n == k) return i;
                n++;
            end
        end
        return 0;
    endfunction

    function automatic logic [31:0] exp_ev(input logic [1:0] r, input logic [3:0] q,
                                           input logic [1:0][9:0] e);
        logic [31:0] v = '0;
        for (int m = 0; m < 2; m++) begin
            if (r[m])       v[12*m]     = 1'b1;
            if (q[2*m])     v[12*m + 4] = 1'b1;
            if (q[2*m + 1]) v[12*m + 8] = 1'b1;
            for (int k = 0; k < 10; k++)
                if (e[m][k]) v[kth(m == 0 ? 32'h1800_0EE6 : 32'h60EE_6000, k)] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d,
                       input logic [1:0] r, input logic [3:0] q, input logic [1:0][9:0] e,
                       input logic [31:0] ackw, input string tag);
        logic [31:0] ev;
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; rd_done = r; q_rep = q; err = e;
        @(posedge clk);
        ev = exp_ev(r, q, e) | ackw;
        if (we && a == 5'h10) m_st = m_st & ~d;
        m_st = m_st | ev;
        if ((ev & m_mask) != 0)              m_arm = 1'b1;
        else if (we && a == 5'h18 && d[0])   m_arm = 1'b0;
        if (we && a == 5'h0C)                m_mask = d;
        #2;
        wr_en = 1'b0; addr = 5'h14; rd_done = '0; q_rep = '0; err = '0;
        #1;
        chk({tag, " status"}, rdata, m_st);
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_arm && ((m_st & m_mask) != 0)});
    endtask

    task automatic idle(input logic [31:0] ackw, input string tag);
        cyc(1'b0, 5'h14, '0, '0, '0, '0, ackw, tag);
    endtask

    task automatic rdreg(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 v = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state and map
        rdreg(5'h00, v); chk("R1 version", v, VER);
        rdreg(5'h14, v); chk("R1 status", v, 0);
        rdreg(5'h0C, v); chk("R1 mask", v, 0);
        rdreg(5'h10, v); chk("R1 write-only reads 0", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 event positions
        cyc(1'b0, 5'h14, 0, 2'b10, 4'b1000, '0, 0, "R2");
        rdreg(5'h14, v); chk("R2 bits 12,20", v, 32'h0010_1000);
        cyc(1'b1, 5'h10, 32'hFFFF_FFFF, '0, '0, '0, 0, "R4 clear all");

        // R3 error positions
        cyc(1'b0, 5'h14, 0, '0, '0, {10'b00_0000_0001, 10'b10_0000_0000}, 0, "R3");
        rdreg(5'h14, v); chk("R3 bits 13,28", v, 32'h1000_2000);

        // R4 event beats clear in same cycle
        cyc(1'b1, 5'h10, 32'hFFFF_FFFF, '0, 4'b0001, '0, 0, "R4 collision");
        rdreg(5'h14, v); chk("R4 bit4 kept", v, 32'h0000_0010);

        // R5 mask readback and irq
        cyc(1'b1, 5'h0C, 32'h0000_0010, '0, '0, '0, 0, "R5 mask");
        rdreg(5'h0C, v); chk("R5 mask readback", v, 32'h0000_0010);
        cyc(1'b0, 5'h14, 0, '0, 4'b0001, '0, 0, "R5 event");
        chk("R5 irq high", {31'b0, irq}, 1);

        // R6 global clear and re-arm
        cyc(1'b1, 5'h18, 1, '0, '0, '0, 0, "R6 gclr");
        chk("R6 irq low", {31'b0, irq}, 0);
        cyc(1'b0, 5'h14, 0, 2'b01, '0, '0, 0, "R6 unmasked event");
        chk("R6 still low", {31'b0, irq}, 0);
        cyc(1'b0, 5'h14, 0, '0, 4'b0001, '0, 0, "R6 masked event");
        chk("R6 rearmed", {31'b0, irq}, 1);
        cyc(1'b1, 5'h10, 32'hFFFF_FFFF, '0, '0, '0, 0, "R4 clear all");
        cyc(1'b1, 5'h0C, 0, '0, '0, '0, 0, "R5 mask off");

        // R7 halt master 0 with repeated request
        cyc(1'b1, 5'h08, 1, '0, '0, '0, 0, "R7 halt0");
        chk("R7 busy start", {30'b0, hbusy}, 1);
        for (int k = 1; k <= HD; k++) begin
            cyc(k == 2, 5'h08, 1, '0, '0, '0, (k == HD) ? 32'h0200_0000 : 0, "R7 halt0 wait");
            chk("R7 busy", {30'b0, hbusy}, (k < HD) ? 1 : 0);
        end
        // R7 both masters
        cyc(1'b1, 5'h08, 3, '0, '0, '0, 0, "R7 halt both");
        for (int k = 1; k <= HD; k++) begin
            cyc(1'b0, 5'h14, 0, '0, '0, '0, (k == HD) ? 32'h0600_0000 : 0, "R7 both wait");
            chk("R7 both busy", {30'b0, hbusy}, (k < HD) ? 3 : 0);
        end
        cyc(1'b1, 5'h10, 32'hFFFF_FFFF, '0, '0, '0, 0, "R4 clear all");

        // R8 reset commands
        for (int t = 0; t < 3; t++) begin
            logic [31:0] w;
            logic [1:0]  sel;
            w   = (t == 0) ? 32'h0003_F001 : (t == 1) ? 32'h0F73_F3F7 : 32'h0000_03F1;
            sel = (t == 0) ? 2'b10 : (t == 1) ? 2'b11 : 2'b01;
            cyc(1'b1, 5'h04, w, '0, '0, '0, 0, "R8 cmd");
            for (int k = 1; k <= RD; k++) begin
                chk("R8 strobe", {30'b0, mrst}, (k == RD) ? {30'b0, sel} : 0);
                cyc(1'b0, 5'h14, 0, '0, '0, '0, (k == RD) ? 32'h0100_0000 : 0, "R8 wait");
            end
            cyc(1'b1, 5'h10, 32'hFFFF_FFFF, '0, '0, '0, 0, "R4 clear all");
        end
        // R8 zero command ignored
        cyc(1'b1, 5'h04, 0, '0, '0, '0, 0, "R8 zero cmd");
        for (int k = 0; k < RD + 3; k++) begin
            chk("R8 zero strobe", {30'b0, mrst}, 0);
            idle(0, "R8 zero wait");
        end

        // R4 R5 R6 random traffic
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] d;
            logic [1:0] r;
            logic [3:0] q;
            logic [1:0][9:0] e;
            op = $urandom % 8;
            d  = $urandom;
            r  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b0;
            q  = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
            e  = '0;
            if ($urandom % 8 == 0) e[0] = 10'($urandom);
            if ($urandom % 8 == 0) e[1] = 10'($urandom);
            case (op)
                0: cyc(1'b1, 5'h10, d, r, q, e, 0, "R4 random");
                1: cyc(1'b1, 5'h0C, d, r, q, e, 0, "R5 random");
                2: cyc(1'b1, 5'h18, d, r, q, e, 0, "R6 random");
                default: cyc(1'b0, 5'h14, 0, r, q, e, 0, "R2 random");
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule